// File: doc/BRIEF.md
# GPIO Edge-to-Interrupt Line Controller

This block watches general-purpose input pins and turns selected edges on them into interrupt requests. It serves sixteen interrupt lines. Line n can listen to pin n of any one of six 16-bit ports, chosen by a 4-bit selector code. Pins with the same number on different ports therefore share one line, and only one of them is heard at a time.

Each line has its own mask bit, a rising-edge enable and a falling-edge enable. Every pin is brought into the clock domain through a two-flop synchronizer. An enabled edge on an unmasked line latches a pending bit, which holds until software clears it by writing a one.

The pending bits, gated by the mask, drive seven request outputs. Lines 0 to 4 each have an output of their own. Lines 5 to 9 share one output and lines 10 to 15 share another. Software reads the pending register to find which line in a shared group fired.

Each line runs a two-state machine:
- `LS_SETTLE`: edge detection is off.
- `LS_WATCH`: edges are detected.

The transitions are:
- Reset enters `LS_SETTLE`.
- `LS_SETTLE` goes to `LS_WATCH` after one cycle with no selector change (transition *settle_done*).
- A write that changes the line's selector code sends either state back to `LS_SETTLE` (transition *reroute*).
- `LS_WATCH` otherwise stays in `LS_WATCH` (transition *keep_watch*).

Because of this, switching a line from one port to another never looks like an edge.

Top module: `extint_line_ctrl`

## Requirements
- R1: After reset, every register reads 0: masks, rising and falling enables, pending bits and all selectors (port 0). All request outputs are 0.
- R2: The register word addresses are fixed:
  - 0 is the mask.
  - 1 is the rising enable.
  - 2 is the falling enable.
  - 3 is the pending register.
  - 4 to 7 are the selectors.
  
  For the first four registers, bit n belongs to line n. Reads return the stored value in bits 15:0, and bits 31:16 read 0. Reads are combinational from `reg_addr`.
- R3: Selector register 4+g holds lines 4g to 4g+3. Line 4g+k uses bits 4k+3:4k. A code p from 0 to 5 routes port p pin n to line n, where that pin is `gpio_in` bit p*16+n. Codes 6 to 15 route a constant 0. A pin with a different number never reaches line n.
- R4: With its mask and rising enable set, a 0-to-1 change on the selected pin sets the line's pending bit at the third rising clock edge after the change.
- R5: With only the falling enable set, a 1-to-0 change sets pending and a rising change does not. With both enables set, either change sets pending.
- R6: A line whose mask bit is 0 never sets pending. The line's request is its pending bit AND its mask bit, so clearing the mask hides a pending bit without erasing it.
- R7: Writing 1 to a pending bit clears it, and writing 0 has no effect. If an edge sets the bit at the same clock edge as the clear, the bit stays set.
- R8: `irq[0]` to `irq[4]` are the requests of lines 0 to 4. `irq[5]` is the OR of the requests of lines 5 to 9. `irq[6]` is the OR of the requests of lines 10 to 15.
- R9: Changes on pins of ports other than the selected one have no effect on a line.
- R10: A selector write that changes a line's code does not set that line's pending bit, even when the old and new pins differ. A later real edge on the new pin is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, taken at the rising clock edge |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| gpio_in | input | 96 | Six 16-bit ports; port p pin n at bit p*16+n |
| irq | output | 7 | Interrupt request outputs |

## Verification
A pin change driven between clock edges shows up in the pending register and on `irq` only after the third rising clock edge that follows it. That is two synchronizer stages plus the pending flop. The bench therefore waits three falling edges after each pin change before it reads anything.

Register writes and W1C clears take effect at the single rising edge inside the write task, and reads are combinational, so they are checked at the next falling edge. The set-wins case is timed so that the clear lands exactly on the third edge after a pin change.

The selector-switch cases are also read several cycles later, once any false edge would already have been latched.

// File: rtl/extint_pkg.sv
package extint_pkg;

    localparam int unsigned EXT_LINES  = 16;
    localparam int unsigned EXT_PORTS  = 6;
    localparam int unsigned EXT_SEL_W  = 4;
    localparam int unsigned REG_AW     = 3;

    localparam logic [REG_AW-1:0] ADR_MASK = 3'd0;
    localparam logic [REG_AW-1:0] ADR_RISE = 3'd1;
    localparam logic [REG_AW-1:0] ADR_FALL = 3'd2;
    localparam logic [REG_AW-1:0] ADR_PEND = 3'd3;
    localparam int unsigned       ADR_SEL_BASE = 4;

    typedef enum logic {
        LS_SETTLE = 1'b0,
        LS_WATCH  = 1'b1
    } line_state_e;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int unsigned WIDTH  = 96,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[s] <= '0;
                else        chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/extint_line.sv
module extint_line
    import extint_pkg::*;
#(
    parameter int unsigned PORTS = EXT_PORTS,
    parameter int unsigned SEL_W = EXT_SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] pins,
    input  logic [SEL_W-1:0] sel,
    input  logic             sel_chg,
    input  logic             rise_en,
    input  logic             fall_en,
    output logic             edge_hit
);

    line_state_e state_q, state_d;
    logic        cur;
    logic        prev_q;

    // port multiplexer: codes beyond the port count give 0
    always_comb begin
        cur = 1'b0;
        for (int p = 0; p < PORTS; p++) begin
            if (sel == SEL_W'(p)) cur = pins[p];
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LS_SETTLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LS_SETTLE: state_d = sel_chg ? LS_SETTLE : LS_WATCH;
            LS_WATCH:  state_d = sel_chg ? LS_SETTLE : LS_WATCH;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    // outputs
    always_comb begin
        edge_hit = 1'b0;
        unique case (state_q)
            LS_SETTLE: edge_hit = 1'b0;
            LS_WATCH:  edge_hit = (rise_en &  cur & ~prev_q) |
                                  (fall_en & ~cur &  prev_q);
        endcase
    end

endmodule

// File: rtl/extint_regs.sv
module extint_regs
    import extint_pkg::*;
#(
    parameter int unsigned LINES         = EXT_LINES,
    parameter int unsigned SEL_W         = EXT_SEL_W,
    parameter int unsigned LINES_PER_SEL = 4,
    parameter int unsigned DW            = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [REG_AW-1:0]      addr,
    input  logic [DW-1:0]          wdata,
    input  logic [LINES-1:0]       edge_hit,
    output logic [DW-1:0]          rdata,
    output logic [LINES-1:0]       mask_q,
    output logic [LINES-1:0]       rise_q,
    output logic [LINES-1:0]       fall_q,
    output logic [LINES-1:0]       pend_q,
    output logic [LINES*SEL_W-1:0] sel_flat,
    output logic [LINES-1:0]       sel_chg
);

    localparam int unsigned SEL_REGS = LINES / LINES_PER_SEL;
    localparam int unsigned SEL_BITS = LINES_PER_SEL * SEL_W;

    logic             wr_mask, wr_rise, wr_fall, wr_pend;
    logic [LINES-1:0] pend_clr;
    logic             unused_wdata_hi;

    assign wr_mask  = wr_en && (addr == ADR_MASK);
    assign wr_rise  = wr_en && (addr == ADR_RISE);
    assign wr_fall  = wr_en && (addr == ADR_FALL);
    assign wr_pend  = wr_en && (addr == ADR_PEND);
    assign pend_clr = wr_pend ? wdata[LINES-1:0] : '0;
    assign unused_wdata_hi = ^wdata[DW-1:LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            rise_q <= '0;
            fall_q <= '0;
            pend_q <= '0;
        end else begin
            if (wr_mask) mask_q <= wdata[LINES-1:0];
            if (wr_rise) rise_q <= wdata[LINES-1:0];
            if (wr_fall) fall_q <= wdata[LINES-1:0];
            // a new edge wins over a same-cycle clear
            pend_q <= (pend_q & ~pend_clr) | (edge_hit & mask_q);
        end
    end

    for (genvar l = 0; l < LINES; l++) begin : g_sel
        localparam int unsigned GRP = l / LINES_PER_SEL;
        localparam int unsigned FLD = l % LINES_PER_SEL;
        logic [SEL_W-1:0] sel_q;
        logic             hit;

        assign hit        = wr_en && (addr == REG_AW'(ADR_SEL_BASE + GRP));
        assign sel_chg[l] = hit && (wdata[FLD*SEL_W +: SEL_W] != sel_q);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   sel_q <= '0;
            else if (hit) sel_q <= wdata[FLD*SEL_W +: SEL_W];
        end

        assign sel_flat[l*SEL_W +: SEL_W] = sel_q;
    end

    always_comb begin
        rdata = '0;
        if (addr == ADR_MASK) rdata[LINES-1:0] = mask_q;
        if (addr == ADR_RISE) rdata[LINES-1:0] = rise_q;
        if (addr == ADR_FALL) rdata[LINES-1:0] = fall_q;
        if (addr == ADR_PEND) rdata[LINES-1:0] = pend_q;
        for (int g = 0; g < SEL_REGS; g++) begin
            if (addr == REG_AW'(ADR_SEL_BASE + g))
                rdata[SEL_BITS-1:0] = sel_flat[g*SEL_BITS +: SEL_BITS];
        end
    end

endmodule

// File: rtl/extint_irq_map.sv
module extint_irq_map #(
    parameter int unsigned LINES = 16,
    parameter int unsigned SOLO  = 5,
    parameter int unsigned SPLIT = 10
) (
    input  logic [LINES-1:0] req,
    output logic [SOLO+1:0]  irq
);

    for (genvar i = 0; i < SOLO; i++) begin : g_solo
        assign irq[i] = req[i];
    end

    assign irq[SOLO]   = |req[SPLIT-1:SOLO];
    assign irq[SOLO+1] = |req[LINES-1:SPLIT];

endmodule

// File: rtl/extint_line_ctrl.sv
module extint_line_ctrl
    import extint_pkg::*;
#(
    parameter int unsigned LINES         = EXT_LINES,
    parameter int unsigned PORTS         = EXT_PORTS,
    parameter int unsigned SEL_W         = EXT_SEL_W,
    parameter int unsigned LINES_PER_SEL = 4,
    parameter int unsigned SOLO_LINES    = 5,
    parameter int unsigned SPLIT_LINE    = 10,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned DW            = 32,
    localparam int unsigned IRQS         = SOLO_LINES + 2,
    localparam int unsigned PINS         = PORTS * LINES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [PINS-1:0]   gpio_in,
    output logic [IRQS-1:0]   irq
);

    logic [PINS-1:0]        pins_sync;
    logic [LINES-1:0]       edge_hit;
    logic [LINES-1:0]       mask_w, rise_w, fall_w, pend_w;
    logic [LINES*SEL_W-1:0] sel_flat;
    logic [LINES-1:0]       sel_chg;

    extint_sync #(
        .WIDTH  (PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (gpio_in),
        .q     (pins_sync)
    );

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [PORTS-1:0] pins_l;
        for (genvar p = 0; p < PORTS; p++) begin : g_pin
            assign pins_l[p] = pins_sync[p*LINES + l];
        end

        extint_line #(
            .PORTS (PORTS),
            .SEL_W (SEL_W)
        ) u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .pins     (pins_l),
            .sel      (sel_flat[l*SEL_W +: SEL_W]),
            .sel_chg  (sel_chg[l]),
            .rise_en  (rise_w[l]),
            .fall_en  (fall_w[l]),
            .edge_hit (edge_hit[l])
        );
    end

    extint_regs #(
        .LINES         (LINES),
        .SEL_W         (SEL_W),
        .LINES_PER_SEL (LINES_PER_SEL),
        .DW            (DW)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .edge_hit (edge_hit),
        .rdata    (reg_rdata),
        .mask_q   (mask_w),
        .rise_q   (rise_w),
        .fall_q   (fall_w),
        .pend_q   (pend_w),
        .sel_flat (sel_flat),
        .sel_chg  (sel_chg)
    );

    extint_irq_map #(
        .LINES (LINES),
        .SOLO  (SOLO_LINES),
        .SPLIT (SPLIT_LINE)
    ) u_map (
        .req (pend_w & mask_w),
        .irq (irq)
    );

endmodule

// File: rtl/extint_line_ctrl_chk.sv
module extint_line_ctrl_chk
    import extint_pkg::*;
#(
    parameter int unsigned LINES = 16,
    parameter int unsigned IRQS  = 7,
    parameter int unsigned SOLO  = 5,
    parameter int unsigned SPLIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [LINES-1:0]  mask_w,
    input logic [LINES-1:0]  rise_w,
    input logic [LINES-1:0]  fall_w,
    input logic [LINES-1:0]  pend_w,
    input logic [IRQS-1:0]   irq
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pend_w == '0 && mask_w == '0 && rise_w == '0 && fall_w == '0));

    // R7
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == ADR_PEND) |=> ((pend_w & $past(pend_w)) == $past(pend_w)));

    // R6
    pend_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_w & ~$past(pend_w) & ~$past(mask_w)) == '0));

    // R5
    pend_needs_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_w & ~$past(pend_w) & ~($past(rise_w) | $past(fall_w))) == '0));

    // R8
    irq_solo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq[SOLO-1:0] == (pend_w[SOLO-1:0] & mask_w[SOLO-1:0]));

    // R8
    irq_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq[SOLO] == |(pend_w[SPLIT-1:SOLO] & mask_w[SPLIT-1:SOLO])) &&
        (irq[SOLO+1] == |(pend_w[LINES-1:SPLIT] & mask_w[LINES-1:SPLIT])));

endmodule

bind extint_line_ctrl extint_line_ctrl_chk #(
    .LINES (LINES),
    .IRQS  (IRQS),
    .SOLO  (SOLO_LINES),
    .SPLIT (SPLIT_LINE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .mask_w   (mask_w),
    .rise_w   (rise_w),
    .fall_w   (fall_w),
    .pend_w   (pend_w),
    .irq      (irq)
);

// File: tb/test_extint_line_ctrl.sv
module test_extint_line_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [95:0] gpio_in;
    logic [6:0]  irq;

    int vectors     = 0;
    int miscompares = 0;
    bit finished    = 1'b0;

    always #5 clk = ~clk;

    extint_line_ctrl i_extint_line_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .gpio_in   (gpio_in),
        .irq       (irq)
    );

    function automatic logic [6:0] exp_irq(input logic [15:0] req);
        logic [6:0] r = '0;
        for (int l = 0; l < 16; l++) begin
            if (req[l]) r[l < 5 ? l : (l < 10 ? 5 : 6)] = 1'b1;
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_pend(input string tag, input logic [15:0] exp, input logic [15:0] msk);
        logic [31:0] v;
        rd(3'd3, v);
        check(tag, v, {16'h0, exp});
        check({tag, " irq (R8)"}, {25'h0, irq}, {25'h0, exp_irq(exp & msk)});
    endtask

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; gpio_in = '0;
        settle(3);
        rst_n = 1'b1;
        settle(2);

        // R1: reset values
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reset register", v, 32'h0);
        end
        check("R1 reset irq", {25'h0, irq}, 32'h0);

        // R2: register map and readback width
        wr(3'd0, 32'hA5A5_1234); rd(3'd0, v); check("R2 mask readback", v, 32'h1234);
        wr(3'd1, 32'hFFFF_8001); rd(3'd1, v); check("R2 rise readback", v, 32'h8001);
        wr(3'd2, 32'h0F0F_4002); rd(3'd2, v); check("R2 fall readback", v, 32'h4002);
        wr(3'd7, 32'hDEAD_5432); rd(3'd7, v); check("R2 selector readback", v, 32'h5432);
        rd(3'd3, v); check("R2 pending untouched", v, 32'h0);
        wr(3'd0, 0); wr(3'd1, 0); wr(3'd2, 0); wr(3'd7, 0);

        // R3 R4 R9 R7 R8: sweep every line over every port
        for (int l = 0; l < 16; l++) begin
            for (int p = 0; p < 6; p++) begin
                wr(3'd1, 0); wr(3'd2, 0);
                gpio_in = '0; settle(3);
                wr(3'd3, 32'hFFFF);
                wr(3'(4 + l / 4), 32'(p) << (4 * (l % 4)));
                wr(3'd0, 32'(1) << l);
                wr(3'd1, 32'(1) << l);
                settle(2);
                gpio_in[((p + 1) % 6) * 16 + l] = 1'b1; settle(3);
                chk_pend("R9 other port pin", 16'h0, 16'(1 << l));
                gpio_in = '0; settle(3);
                gpio_in[p * 16 + (l + 1) % 16] = 1'b1; settle(3);
                chk_pend("R3 other pin number", 16'h0, 16'(1 << l));
                gpio_in = '0; settle(3);
                gpio_in[p * 16 + l] = 1'b1; settle(3);
                chk_pend("R4 rising edge", 16'(1 << l), 16'(1 << l));
                wr(3'd3, 32'(1) << l);
                chk_pend("R7 clear by one", 16'h0, 16'(1 << l));
                gpio_in[p * 16 + l] = 1'b0; settle(3);
                chk_pend("R5 fall disabled", 16'h0, 16'(1 << l));
            end
        end
        wr(3'd4, 0); wr(3'd5, 0); wr(3'd6, 0); wr(3'd7, 0);

        // R5: line 6 on port 3 (field bits 11:8 of selector word 5)
        wr(3'd5, 32'h0000_0300); wr(3'd0, 32'h40); wr(3'd1, 0); wr(3'd2, 32'h40);
        settle(2);
        gpio_in[3*16+6] = 1'b1; settle(3);
        chk_pend("R5 rise ignored", 16'h0, 16'h40);
        gpio_in[3*16+6] = 1'b0; settle(3);
        chk_pend("R5 fall sets", 16'h40, 16'h40);
        wr(3'd3, 32'h40);
        wr(3'd1, 32'h40);
        gpio_in[3*16+6] = 1'b1; settle(3);
        chk_pend("R5 both, rise", 16'h40, 16'h40);
        wr(3'd3, 32'h40);
        gpio_in[3*16+6] = 1'b0; settle(3);
        chk_pend("R5 both, fall", 16'h40, 16'h40);
        wr(3'd3, 32'h40);

        // R6: mask
        wr(3'd0, 0);
        gpio_in[3*16+6] = 1'b1; settle(3);
        chk_pend("R6 masked edge", 16'h0, 16'h0);
        wr(3'd0, 32'h40);
        gpio_in[3*16+6] = 1'b0; settle(3);
        chk_pend("R6 unmasked edge", 16'h40, 16'h40);
        wr(3'd0, 0);
        chk_pend("R6 mask hides request", 16'h40, 16'h0);
        wr(3'd0, 32'h40);
        chk_pend("R6 mask restores request", 16'h40, 16'h40);

        // R7: write zero, then set wins over clear
        wr(3'd3, 0);
        chk_pend("R7 write zero no effect", 16'h40, 16'h40);
        gpio_in[3*16+6] = 1'b1;
        @(negedge clk);
        wr(3'd3, 32'h40);
        chk_pend("R7 set wins over clear", 16'h40, 16'h40);
        wr(3'd3, 32'h40);
        chk_pend("R7 final clear", 16'h0, 16'h40);
        wr(3'd5, 0); gpio_in = '0; wr(3'd2, 0); settle(3);

        // R8: shared outputs with several lines
        wr(3'd0, 32'hFFFF); wr(3'd1, 32'hFFFF); wr(3'd3, 32'hFFFF);
        gpio_in[7] = 1'b1; gpio_in[9] = 1'b1; settle(3);
        chk_pend("R8 lines 7 and 9", 16'h0280, 16'hFFFF);
        wr(3'd3, 32'h80);
        chk_pend("R8 line 9 keeps shared", 16'h0200, 16'hFFFF);
        wr(3'd3, 32'h200);
        chk_pend("R8 shared drops", 16'h0, 16'hFFFF);
        gpio_in[0] = 1'b1; gpio_in[4] = 1'b1; gpio_in[10] = 1'b1; gpio_in[15] = 1'b1; settle(3);
        chk_pend("R8 mixed lines", 16'h8411, 16'hFFFF);
        check("R8 mixed irq pattern", {25'h0, irq}, 32'h51);
        wr(3'd3, 32'hFFFF);
        wr(3'd1, 0); gpio_in = '0; settle(3); wr(3'd3, 32'hFFFF);

        // R10: port switch on line 3 (field bits 15:12 of selector word 4)
        wr(3'd0, 32'h8); wr(3'd1, 32'h8); wr(3'd2, 32'h8);
        gpio_in[1*16+3] = 1'b1; settle(3);
        chk_pend("R10 idle before switch", 16'h0, 16'h8);
        wr(3'd4, 32'h1000); settle(4);
        chk_pend("R10 switch to high pin", 16'h0, 16'h8);
        wr(3'd4, 32'h0); settle(4);
        chk_pend("R10 switch to low pin", 16'h0, 16'h8);
        gpio_in[3] = 1'b1; settle(3);
        chk_pend("R10 real edge after switch", 16'h8, 16'h8);
        wr(3'd3, 32'h8);
        gpio_in = '0; settle(3); wr(3'd3, 32'hFFFF);

        // R3: unused selector code routes 0
        wr(3'd4, 32'h0700); wr(3'd0, 32'h4); wr(3'd1, 32'h4); wr(3'd2, 0);
        rd(3'd4, v); check("R3 code 7 readback", v, 32'h0700);
        settle(2);
        for (int p = 0; p < 6; p++) gpio_in[p*16+2] = 1'b1;
        settle(3);
        chk_pend("R3 code 7 ignores all ports", 16'h0, 16'h4);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog (all): got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule